// File: doc/BRIEF.md
# Password Verifier with Retry Lockout

This block decides whether a secure session may proceed. A session opens with a start strobe that names one of three stored 64-bit keys (write, read or configuration) and says whether it is a plain check or a key change. The key material then arrives one byte per valid strobe. After the last byte the block compares the received key with the stored one, updates an 8-bit attempt counter and opens a fixed busy window that stands for the nonvolatile update. During that window every acknowledge poll is answered with no-ACK. After the window, only a correct key gives ACK to a poll carrying the code C0h. The window is the same length for a correct key, a wrong key and a refused attempt, so a caller cannot learn the result early.

The attempt counter is compared with a limit register before each check. While they are equal the block is locked. A lock-mode field chooses between refusing everything and still accepting the configuration key. A key change is entered as the old key followed by two copies of the new key. The new key is stored only when the old key matches and the two copies agree. The serial bus front end and the real storage cells sit outside this block.

Top module: `pass_gate`

## Requirements
- R1: After reset, grant, busy and ack are 0, retry_cnt is 0 and all three stored keys are all zeros.
- R2: From the cycle after the last key byte is accepted, busy stays high for exactly BUSY_CYCLES+1 cycles, whatever the outcome. A poll made while busy is high is answered with ack 0.
- R3: When the key is correct and the attempt is allowed, grant is 1 once busy falls. A poll with byte_in = C0h is answered with ack 1 in the following cycle.
- R4: When the key is wrong, grant stays 0 and a C0h poll after the busy window still gives ack 0.
- R5: A poll whose code differs from C0h gives ack 0 even after a correct key.
- R6: key_sel encodes 0 = write key, 1 = read key, 2 = configuration key. Code 3 never matches. The first byte of a key is its most significant byte.
- R7: With cnt_en = 1, a wrong key on an unlocked attempt adds 1 to retry_cnt modulo 256, so 255 wraps to 0.
- R8: With cnt_en = 1, a correct key clears retry_cnt when cnt_clr_ok = 1 and leaves it unchanged when cnt_clr_ok = 0. With cnt_en = 0, retry_cnt never changes on a check.
- R9: With cnt_en = 1 and retry_cnt equal to retry_limit, an attempt is refused (grant 0, ack 0) and retry_cnt does not change. When lock_mode = 2'b11, the configuration key is still granted. Any other lock_mode refuses all keys.
- R10: With prog = 1 the session takes 24 bytes: old key, new key, new key again. The selected key is replaced by the new key only when the old key matches and the two copies are equal; otherwise it keeps its value and polls get ack 0.
- R11: An abort pulse returns the block to idle from any state and drops grant.
- R12: A cnt_load pulse writes cnt_load_val into retry_cnt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a session (accepted in idle or after a result) |
| prog | input | 1 | With start: 1 = key change, 0 = check |
| key_sel | input | 2 | With start: key chosen (R6 encoding) |
| abort | input | 1 | Ends the session, back to idle |
| byte_vld | input | 1 | byte_in carries a key byte |
| byte_in | input | 8 | Key byte, or poll code when poll is high |
| poll | input | 1 | Acknowledge poll strobe |
| cnt_en | input | 1 | Retry counting enabled |
| cnt_clr_ok | input | 1 | Clear counter on correct key |
| lock_mode | input | 2 | Behaviour when locked |
| retry_limit | input | 8 | Retry limit register |
| cnt_load | input | 1 | Load retry counter |
| cnt_load_val | input | 8 | Value for cnt_load |
| grant | output | 1 | Access granted for this session |
| ack | output | 1 | Poll answer: 1 = ACK, 0 = no-ACK |
| busy | output | 1 | Update window active |
| retry_cnt | output | 8 | Current retry counter |

## Verification
The hardest state to reach is lockout, together with the counter wrapping past its top into it. The bench gets there by loading the counter to just below the limit, or to 255 with a small limit, and then sending deliberately wrong keys. It then checks that a correct key is refused, that the window length does not change, and that the configuration key is still accepted in the override mode. Key changes are exercised with both matching and mismatching copies, and the stored key is then read back through the port with a later check session.

// File: rtl/pg_pkg.sv
package pg_pkg;
   typedef enum logic [1:0] {
      KEY_WR   = 2'd0,
      KEY_RD   = 2'd1,
      KEY_CFG  = 2'd2,
      KEY_NONE = 2'd3
   } key_sel_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FILL,
      ST_EVAL,
      ST_BUSY,
      ST_DONE
   } gate_state_e;

   localparam logic [1:0] LOCK_CFG_ONLY = 2'b11;
endpackage

// File: rtl/pg_collect.sv
module pg_collect #(
   parameter int BYTE_W    = 8,
   parameter int KEY_BYTES = 8,
   parameter int SLOTS     = 3
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 clear,
   input  logic                                 vld,
   input  logic [BYTE_W-1:0]                    din,
   output logic [SLOTS*KEY_BYTES*BYTE_W-1:0]    shreg,
   output logic [$clog2(SLOTS*KEY_BYTES+1)-1:0] count
);
   localparam int BUF_W = SLOTS*KEY_BYTES*BYTE_W;
   localparam int CW    = $clog2(SLOTS*KEY_BYTES+1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         count <= '0;
      end else if (clear) begin
         shreg <= '0;
         count <= '0;
      end else if (vld) begin
         shreg <= {shreg[BUF_W-BYTE_W-1:0], din};
         count <= count + CW'(1);
      end
   end
endmodule

// File: rtl/pg_keystore.sv
module pg_keystore #(
   parameter int KEY_W = 64,
   parameter int NKEYS = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [1:0]               wr_idx,
   input  logic [KEY_W-1:0]         wr_key,
   input  logic [1:0]               rd_idx,
   output logic [KEY_W-1:0]         rd_key,
   output logic                     rd_ok
);
   logic [NKEYS*KEY_W-1:0] flat;

   generate
      if (NKEYS < 1 || NKEYS > 3) begin : g_bad_nkeys
         $error("pg_keystore: NKEYS must be 1 to 3");
      end
      for (genvar g = 0; g < NKEYS; g++) begin : g_key
         logic [KEY_W-1:0] k;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               k <= '0;
            else if (wr_en && wr_idx == 2'(g))
               k <= wr_key;
         end
         assign flat[g*KEY_W +: KEY_W] = k;
      end
   endgenerate

   always_comb begin
      rd_key = '0;
      rd_ok  = 1'b0;
      for (int i = 0; i < NKEYS; i++) begin
         if (rd_idx == 2'(i)) begin
            rd_key = flat[i*KEY_W +: KEY_W];
            rd_ok  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/pg_retry.sv
module pg_retry #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             clr_on_ok,
   input  logic [CNT_W-1:0] limit,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             eval,
   input  logic             pass,
   output logic             locked,
   output logic [CNT_W-1:0] cnt
);
   assign locked = cnt_en && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (eval && cnt_en && !locked) begin
         if (!pass)
            cnt <= cnt + CNT_W'(1);
         else if (clr_on_ok)
            cnt <= '0;
      end
   end

   assert_idle_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!eval && !load) |=> $stable(cnt));
   assert_locked_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && !load && locked) |=> $stable(cnt));
   assert_bad_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && !load && cnt_en && !locked && !pass) |=> (cnt == $past(cnt) + CNT_W'(1)));
   assert_off_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !load) |=> $stable(cnt));
endmodule

// File: rtl/pass_gate.sv
module pass_gate
   import pg_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int KEY_BYTES   = 8,
   parameter int CNT_W       = 8,
   parameter int BUSY_CYCLES = 40,
   parameter int POLL_CODE   = 192
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              prog,
   input  logic [1:0]        key_sel,
   input  logic              abort,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              poll,
   input  logic              cnt_en,
   input  logic              cnt_clr_ok,
   input  logic [1:0]        lock_mode,
   input  logic [CNT_W-1:0]  retry_limit,
   input  logic              cnt_load,
   input  logic [CNT_W-1:0]  cnt_load_val,
   output logic              grant,
   output logic              ack,
   output logic              busy,
   output logic [CNT_W-1:0]  retry_cnt
);
   localparam int KEY_W = BYTE_W*KEY_BYTES;
   localparam int BUF_W = 3*KEY_W;
   localparam int CW    = $clog2(3*KEY_BYTES+1);
   localparam int TW    = $clog2(BUSY_CYCLES+1);

   generate
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("pass_gate: BUSY_CYCLES must be at least 1");
      end
      if (KEY_BYTES < 1) begin : g_bad_key
         $error("pass_gate: KEY_BYTES must be at least 1");
      end
   endgenerate

   gate_state_e      state;
   key_sel_e         sel_q;
   logic             prog_q, pass_q, ack_q;
   logic [TW-1:0]    timer;
   logic [BUF_W-1:0] shreg;
   logic [CW-1:0]    fill_cnt;
   logic [KEY_W-1:0] stored, cand, new_a, new_b;
   logic             key_ok, key_hit, allowed, pass_now, locked, open_sess;
   logic [CW-1:0]    need_m1;

   assign open_sess = start && !abort && (state == ST_IDLE || state == ST_DONE);
   assign need_m1   = prog_q ? CW'(3*KEY_BYTES-1) : CW'(KEY_BYTES-1);

   pg_collect #(.BYTE_W(BYTE_W), .KEY_BYTES(KEY_BYTES), .SLOTS(3)) u_collect (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (open_sess),
      .vld   (byte_vld && state == ST_FILL),
      .din   (byte_in),
      .shreg (shreg),
      .count (fill_cnt)
   );

   assign new_a = shreg[2*KEY_W-1:KEY_W];
   assign new_b = shreg[KEY_W-1:0];
   assign cand  = prog_q ? shreg[3*KEY_W-1:2*KEY_W] : shreg[KEY_W-1:0];

   pg_keystore #(.KEY_W(KEY_W), .NKEYS(3)) u_keys (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (state == ST_EVAL && pass_now && prog_q),
      .wr_idx (sel_q),
      .wr_key (new_a),
      .rd_idx (sel_q),
      .rd_key (stored),
      .rd_ok  (key_ok)
   );

   assign key_hit  = key_ok && (cand == stored);
   assign allowed  = !locked || (lock_mode == LOCK_CFG_ONLY && sel_q == KEY_CFG);
   assign pass_now = allowed && key_hit && (!prog_q || new_a == new_b);

   pg_retry #(.CNT_W(CNT_W)) u_retry (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_en    (cnt_en),
      .clr_on_ok (cnt_clr_ok),
      .limit     (retry_limit),
      .load      (cnt_load),
      .load_val  (cnt_load_val),
      .eval      (state == ST_EVAL),
      .pass      (key_hit),
      .locked    (locked),
      .cnt       (retry_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         sel_q  <= KEY_WR;
         prog_q <= 1'b0;
         pass_q <= 1'b0;
         timer  <= '0;
      end else if (abort) begin
         state  <= ST_IDLE;
         pass_q <= 1'b0;
      end else if (open_sess) begin
         state  <= ST_FILL;
         sel_q  <= key_sel_e'(key_sel);
         prog_q <= prog;
         pass_q <= 1'b0;
      end else begin
         case (state)
            ST_FILL: if (byte_vld && fill_cnt == need_m1) state <= ST_EVAL;
            ST_EVAL: begin
               pass_q <= pass_now;
               timer  <= TW'(BUSY_CYCLES-1);
               state  <= ST_BUSY;
            end
            ST_BUSY: begin
               if (timer == '0) state <= ST_DONE;
               else             timer <= timer - TW'(1);
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= poll && state == ST_DONE && pass_q && !abort
                           && byte_in == BYTE_W'(POLL_CODE);
   end

   assign ack   = ack_q;
   assign grant = (state == ST_DONE) && pass_q;
   assign busy  = (state == ST_EVAL) || (state == ST_BUSY);

   assert_grant_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant) |-> $past(busy));
   assert_busy_from_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(byte_vld));
   assert_no_ack_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !ack);
   assert_abort_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!grant && !busy));
endmodule

// File: tb/pass_gate_tb_top.sv
module pass_gate_tb_top;
   localparam int BUSY = 20;
   localparam logic [63:0] KZ = 64'h0;
   localparam logic [63:0] KA = 64'h0123_4567_89AB_CDEF;
   localparam logic [63:0] KB = 64'hFEDC_BA98_7654_3210;
   localparam logic [63:0] KC = 64'h1111_2222_3333_4444;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 0, prog = 0, abort = 0, byte_vld = 0, poll = 0;
   logic [1:0] key_sel = 0, lock_mode = 0;
   logic [7:0] byte_in = 0, retry_limit = 8'd200, cnt_load_val = 0;
   logic cnt_en = 0, cnt_clr_ok = 0, cnt_load = 0;
   logic grant, ack, busy;
   logic [7:0] retry_cnt;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   pass_gate #(.BUSY_CYCLES(BUSY)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .prog(prog), .key_sel(key_sel),
      .abort(abort), .byte_vld(byte_vld), .byte_in(byte_in), .poll(poll),
      .cnt_en(cnt_en), .cnt_clr_ok(cnt_clr_ok), .lock_mode(lock_mode),
      .retry_limit(retry_limit), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
      .grant(grant), .ack(ack), .busy(busy), .retry_cnt(retry_cnt)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic load_cnt(input logic [7:0] v);
      @(negedge clk); cnt_load = 1; cnt_load_val = v;
      @(negedge clk); cnt_load = 0;
   endtask

   // One session; reports busy length, mid-window poll answer, final poll answer, grant
   task automatic session(input bit pg, input logic [1:0] sel,
                          input logic [63:0] k0, input logic [63:0] k1, input logic [63:0] k2,
                          output int blen, output logic amid, output logic aend, output logic gr);
      logic [63:0] k;
      @(negedge clk); start = 1; prog = pg; key_sel = sel;
      @(negedge clk); start = 0;
      for (int j = 0; j < (pg ? 24 : 8); j++) begin
         k = (!pg || j < 8) ? k0 : (j < 16 ? k1 : k2);
         byte_vld = 1; byte_in = k[63-8*(j%8) -: 8];
         @(negedge clk);
      end
      byte_vld = 0;
      blen = 0; amid = 1'bx;
      while (busy === 1'b1 && blen < 1000) begin
         poll = (blen == 3); byte_in = 8'hC0;
         @(negedge clk);
         if (blen == 3) amid = ack;
         blen++;
      end
      poll = 1; byte_in = 8'hC0;
      @(negedge clk); poll = 0;
      aend = ack; gr = grant;
   endtask

   task automatic expect_sess(input string tag, input bit pg, input logic [1:0] sel,
                              input logic [63:0] k0, input logic [63:0] k1, input logic [63:0] k2,
                              input bit ok);
      int bl; logic am, ae, g;
      session(pg, sel, k0, k1, k2, bl, am, ae, g);
      chk({tag, " R2 busy length"}, bl, BUSY+1);
      chk({tag, " R2 poll during busy"}, am, 0);
      chk({tag, ok ? " R3 ack" : " R4 ack"}, ae, ok);
      chk({tag, ok ? " R3 grant" : " R4 grant"}, g, ok);
   endtask

   task automatic t_reset;
      chk("R1 grant", grant, 0); chk("R1 busy", busy, 0);
      chk("R1 ack", ack, 0);     chk("R1 retry_cnt", retry_cnt, 0);
      expect_sess("R1 R6 write key zero", 0, 2'd0, KZ, KZ, KZ, 1);
      expect_sess("R1 R6 read key zero", 0, 2'd1, KZ, KZ, KZ, 1);
      expect_sess("R1 R6 cfg key zero", 0, 2'd2, KZ, KZ, KZ, 1);
      expect_sess("R6 code 3 never matches", 0, 2'd3, KZ, KZ, KZ, 0);
   endtask

   task automatic t_program;
      expect_sess("R10 program read key", 1, 2'd1, KZ, KA, KA, 1);
      expect_sess("R10 new read key works", 0, 2'd1, KA, KZ, KZ, 1);
      expect_sess("R10 old read key rejected", 0, 2'd1, KZ, KZ, KZ, 0);
      expect_sess("R6 byte order reversed rejected", 0, 2'd1, {KA[7:0], KA[63:8]}, KZ, KZ, 0);
      expect_sess("R10 copy mismatch", 1, 2'd1, KA, KB, KC, 0);
      expect_sess("R10 key kept after mismatch", 0, 2'd1, KA, KZ, KZ, 1);
      expect_sess("R10 wrong old key", 1, 2'd1, KB, KC, KC, 0);
      expect_sess("R10 key kept after wrong old", 0, 2'd1, KA, KZ, KZ, 1);
      expect_sess("R6 write key separate", 0, 2'd0, KZ, KZ, KZ, 1);
   endtask

   task automatic t_poll_abort;
      expect_sess("R3 pass before poll tests", 0, 2'd0, KZ, KZ, KZ, 1);
      @(negedge clk); poll = 1; byte_in = 8'h55;
      @(negedge clk); poll = 0;
      chk("R5 wrong poll code", ack, 0);
      @(negedge clk); poll = 1; byte_in = 8'hC0;
      @(negedge clk); poll = 0;
      chk("R3 repeat poll", ack, 1);
      @(negedge clk); abort = 1;
      @(negedge clk); abort = 0;
      chk("R11 grant after abort", grant, 0);
      chk("R11 busy after abort", busy, 0);
   endtask

   task automatic t_counter;
      cnt_en = 0; load_cnt(8'd7);
      chk("R12 load", retry_cnt, 7);
      expect_sess("R8 disabled wrong", 0, 2'd0, KB, KZ, KZ, 0);
      chk("R8 disabled no count", retry_cnt, 7);
      cnt_en = 1; retry_limit = 8'd200; cnt_clr_ok = 0;
      expect_sess("R7 wrong counts", 0, 2'd0, KB, KZ, KZ, 0);
      chk("R7 increment", retry_cnt, 8);
      expect_sess("R8 correct no clear", 0, 2'd0, KZ, KZ, KZ, 1);
      chk("R8 keep without clear bit", retry_cnt, 8);
      cnt_clr_ok = 1;
      expect_sess("R8 correct clear", 0, 2'd0, KZ, KZ, KZ, 1);
      chk("R8 cleared", retry_cnt, 0);
      cnt_clr_ok = 0;
   endtask

   task automatic t_lockout;
      retry_limit = 8'd3; lock_mode = 2'b00; load_cnt(8'd2);
      expect_sess("R7 reach limit", 0, 2'd0, KB, KZ, KZ, 0);
      chk("R7 count at limit", retry_cnt, 3);
      expect_sess("R9 locked refuses correct key", 0, 2'd0, KZ, KZ, KZ, 0);
      chk("R9 locked count frozen", retry_cnt, 3);
      expect_sess("R9 mode 00 refuses cfg key", 0, 2'd2, KZ, KZ, KZ, 0);
      lock_mode = 2'b11;
      expect_sess("R9 mode 11 grants cfg key", 0, 2'd2, KZ, KZ, KZ, 1);
      expect_sess("R9 mode 11 refuses write key", 0, 2'd0, KZ, KZ, KZ, 0);
      chk("R9 count still frozen", retry_cnt, 3);
      lock_mode = 2'b00;
   endtask

   task automatic t_wrap;
      retry_limit = 8'd1; load_cnt(8'd255);
      expect_sess("R7 wrong at 255", 0, 2'd0, KC, KZ, KZ, 0);
      chk("R7 wrap to 0", retry_cnt, 0);
      expect_sess("R7 wrong at 0", 0, 2'd0, KC, KZ, KZ, 0);
      chk("R7 count 1", retry_cnt, 1);
      expect_sess("R9 locked after wrap", 0, 2'd0, KZ, KZ, KZ, 0);
      chk("R9 frozen after wrap", retry_cnt, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_program;
      t_poll_abort;
      t_counter;
      t_lockout;
      t_wrap;
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule